// File: doc/BRIEF.md
# Dual-Register Multiplexer Logic Cell

This block is one logic cell of a programmable fabric. The cell is built only from fixed AND gates, 2:1 multiplexers and two D flip-flops. Dynamic data and select inputs feed two wide AND gates and a two-level multiplexer tree. The cell gives four combinational results and two registered results. The first register always captures the upper multiplexer tree result. The second register captures either the lower tree result or a dedicated bypass input. A static configuration parameter makes that choice. In hardware it is a constant bit wired to the select of the seventh multiplexer.

Both registers share one clock, one asynchronous set and one asynchronous reset, all active high, and reset overrides set. Counting the register controls, the cell has 30 inputs. The network uses two wide AND gates, four 2-input AND gates that form the multiplexer selects, seven 2:1 multiplexers and two flip-flops. A fabric instantiates the cell many times and ties the configuration parameter per site.

Top module: `lc_cell`

## Requirements
- R1: `a_o` is the AND of all bits of `and_a_i`, and `f_o` is the AND of all bits of `and_f_i`. Each of these inputs is `AND_WIDTH` bits wide, 6 by default.
- R2: Let U be 1 exactly when both bits of `up_sel_i` are 1, and M be 1 exactly when both bits of `m_sel_i` are 1. Then `m_o` equals `up_d1b_i` when M=1 and U=1, and `up_d1a_i` when M=1 and U=0. It equals `up_d0_i` when M=0 and U=1, and `a_o` when M=0 and U=0.
- R3: `n_o` follows the rule of R2 with the lower inputs. `lo_sel_i` takes the place of `up_sel_i` and `n_sel_i` takes the place of `m_sel_i`. `lo_d0_i`, `lo_d1a_i` and `lo_d1b_i` take the places of the three upper data inputs, and `f_o` takes the place of `a_o`.
- R4: On a rising clock edge with set and reset both low, `q1_o` takes the value `m_o` had before the edge.
- R5: With `Q2_SRC` = `SRC_MUX` (0), a rising edge with set and reset low loads `q2_o` with the value of `n_o`.
- R6: With `Q2_SRC` = `SRC_DIRECT` (1), a rising edge with set and reset low loads `q2_o` with `byp_i`. In this mode the lower tree has no effect on `q2_o`.
- R7: While `set_i` is 1 and `rst_i` is 0, both `q1_o` and `q2_o` are 1. This takes effect at once, with no clock edge, and holds across clock edges.
- R8: While `rst_i` is 1, both `q1_o` and `q2_o` are 0 at once, whatever `set_i` is.
- R9: The combinational outputs `a_o`, `f_o`, `m_o` and `n_o` do not depend on `clk_i`, `set_i` or `rst_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared by both registers |
| set_i | input | 1 | Asynchronous set of both registers, active high |
| rst_i | input | 1 | Asynchronous reset of both registers, active high, overrides set |
| and_a_i | input | AND_WIDTH | Inputs of the first wide AND gate |
| and_f_i | input | AND_WIDTH | Inputs of the second wide AND gate |
| up_sel_i | input | 2 | Inputs of the AND gate that forms the upper first-level select |
| up_d0_i | input | 1 | Upper data, taken when the upper select is 1 and the output select is 0 |
| up_d1a_i | input | 1 | Upper data, taken when the output select is 1 and the upper select is 0 |
| up_d1b_i | input | 1 | Upper data, taken when both upper selects are 1 |
| m_sel_i | input | 2 | Inputs of the AND gate that forms the upper output select |
| lo_sel_i | input | 2 | Inputs of the AND gate that forms the lower first-level select |
| lo_d0_i | input | 1 | Lower data, taken when the lower select is 1 and the output select is 0 |
| lo_d1a_i | input | 1 | Lower data, taken when the output select is 1 and the lower select is 0 |
| lo_d1b_i | input | 1 | Lower data, taken when both lower selects are 1 |
| n_sel_i | input | 2 | Inputs of the AND gate that forms the lower output select |
| byp_i | input | 1 | Dedicated direct input of the second register |
| a_o | output | 1 | First wide AND result |
| f_o | output | 1 | Second wide AND result |
| m_o | output | 1 | Upper multiplexer tree result |
| n_o | output | 1 | Lower multiplexer tree result |
| q1_o | output | 1 | First register |
| q2_o | output | 1 | Second register |

## Verification
Assertions check the following on every clock: that each register loads its source whenever no asynchronous control is active, that q2 follows the source chosen by the configuration, that set holds a register at one, and that reset holds it at zero even with set active. Only the bench scenarios can show the full Boolean function of the combinational outputs across many random select and data patterns, and the single-zero corners of the wide AND gates. They also show that an asynchronous control acts before any clock edge, and that both settings of the configuration parameter differ on the same stimulus.

// File: rtl/lc_pkg.sv
`timescale 1ns/1ps
package lc_pkg;

   // Static choice of what the second register loads
   typedef enum logic {
      SRC_MUX    = 1'b0,
      SRC_DIRECT = 1'b1
   } q2_src_e;

   localparam int unsigned LC_SEL_WIDTH = 2;   // inputs of each select AND gate
   localparam int unsigned LC_MIN_AND   = 2;
   localparam int unsigned LC_MAX_AND   = 16;

endpackage

// File: rtl/lc_and.sv
`timescale 1ns/1ps
module lc_and #(
   parameter int unsigned N = 2
) (
   input  logic [N-1:0] in_i,
   output logic         y_o
);
   if (N < 1) begin : g_bad_width
      $error("lc_and: N must be at least 1");
   end

   assign y_o = &in_i;
endmodule

// File: rtl/lc_mux2.sv
`timescale 1ns/1ps
module lc_mux2 (
   input  logic sel_i,
   input  logic a_i,    // taken when sel_i is 0
   input  logic b_i,    // taken when sel_i is 1
   output logic y_o
);
   assign y_o = sel_i ? b_i : a_i;
endmodule

// File: rtl/lc_mux_stage.sv
`timescale 1ns/1ps
// Two-level tree: two AND-formed selects, three 2:1 muxes
module lc_mux_stage
   import lc_pkg::*;
(
   input  logic [LC_SEL_WIDTH-1:0] first_sel_i,
   input  logic [LC_SEL_WIDTH-1:0] out_sel_i,
   input  logic                    gate_i,
   input  logic                    d0_i,
   input  logic                    d1a_i,
   input  logic                    d1b_i,
   output logic                    y_o
);
   logic s_first, s_out;
   logic leg0, leg1;

   lc_and #(.N(LC_SEL_WIDTH)) u_and_first (.in_i(first_sel_i), .y_o(s_first));
   lc_and #(.N(LC_SEL_WIDTH)) u_and_out   (.in_i(out_sel_i),   .y_o(s_out));

   lc_mux2 u_mux_leg0 (.sel_i(s_first), .a_i(gate_i), .b_i(d0_i),  .y_o(leg0));
   lc_mux2 u_mux_leg1 (.sel_i(s_first), .a_i(d1a_i),  .b_i(d1b_i), .y_o(leg1));
   lc_mux2 u_mux_out  (.sel_i(s_out),   .a_i(leg0),   .b_i(leg1),  .y_o(y_o));

   // R2/R3 corner: both selects high reach the far data input
   always_comb begin
      if ((&first_sel_i) && (&out_sel_i)) begin
         assert_far_leg_R2: assert (y_o == d1b_i);
      end
   end
endmodule

// File: rtl/lc_dff_sr.sv
`timescale 1ns/1ps
module lc_dff_sr (
   input  logic clk_i,
   input  logic set_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   always_ff @(posedge clk_i or posedge rst_i or posedge set_i) begin
      if (rst_i)      q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else            q_o <= d_i;
   end

   assert_capture_R4: assert property (@(posedge clk_i) disable iff (rst_i || set_i)
      1'b1 |=> q_o == $past(d_i));

   assert_set_holds_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      set_i |-> q_o == 1'b1);

   // R8: reset wins; sampled mid-cycle, away from the capture edge
   always @(negedge clk_i) begin
      if (rst_i) begin
         assert_reset_wins_R8: assert (q_o == 1'b0);
      end
   end
endmodule

// File: rtl/lc_cell.sv
`timescale 1ns/1ps
module lc_cell
   import lc_pkg::*;
#(
   parameter int unsigned AND_WIDTH = 6,
   parameter q2_src_e     Q2_SRC    = SRC_MUX
) (
   input  logic                    clk_i,
   input  logic                    set_i,
   input  logic                    rst_i,
   input  logic [AND_WIDTH-1:0]    and_a_i,
   input  logic [AND_WIDTH-1:0]    and_f_i,
   input  logic [LC_SEL_WIDTH-1:0] up_sel_i,
   input  logic                    up_d0_i,
   input  logic                    up_d1a_i,
   input  logic                    up_d1b_i,
   input  logic [LC_SEL_WIDTH-1:0] m_sel_i,
   input  logic [LC_SEL_WIDTH-1:0] lo_sel_i,
   input  logic                    lo_d0_i,
   input  logic                    lo_d1a_i,
   input  logic                    lo_d1b_i,
   input  logic [LC_SEL_WIDTH-1:0] n_sel_i,
   input  logic                    byp_i,
   output logic                    a_o,
   output logic                    f_o,
   output logic                    m_o,
   output logic                    n_o,
   output logic                    q1_o,
   output logic                    q2_o
);
   localparam logic PATH_SEL = (Q2_SRC == SRC_DIRECT);

   if (AND_WIDTH < LC_MIN_AND || AND_WIDTH > LC_MAX_AND) begin : g_bad_and_width
      $error("lc_cell: AND_WIDTH out of supported range");
   end

   logic q2_d;

   // Wide AND gates
   lc_and #(.N(AND_WIDTH)) u_and_a (.in_i(and_a_i), .y_o(a_o));
   lc_and #(.N(AND_WIDTH)) u_and_f (.in_i(and_f_i), .y_o(f_o));

   // Upper and lower multiplexer trees
   lc_mux_stage u_upper (
      .first_sel_i(up_sel_i), .out_sel_i(m_sel_i), .gate_i(a_o),
      .d0_i(up_d0_i), .d1a_i(up_d1a_i), .d1b_i(up_d1b_i), .y_o(m_o));

   lc_mux_stage u_lower (
      .first_sel_i(lo_sel_i), .out_sel_i(n_sel_i), .gate_i(f_o),
      .d0_i(lo_d0_i), .d1a_i(lo_d1a_i), .d1b_i(lo_d1b_i), .y_o(n_o));

   // Seventh mux: select tied to the static configuration bit
   lc_mux2 u_path (.sel_i(PATH_SEL), .a_i(n_o), .b_i(byp_i), .y_o(q2_d));

   lc_dff_sr u_reg1 (.clk_i(clk_i), .set_i(set_i), .rst_i(rst_i), .d_i(m_o),  .q_o(q1_o));
   lc_dff_sr u_reg2 (.clk_i(clk_i), .set_i(set_i), .rst_i(rst_i), .d_i(q2_d), .q_o(q2_o));

   // R1: a zero on any input keeps the wide AND low
   always_comb begin
      if (!(&and_a_i)) assert_and_a_low_R1: assert (a_o == 1'b0);
      if (!(&and_f_i)) assert_and_f_low_R1: assert (f_o == 1'b0);
   end

   if (Q2_SRC == SRC_DIRECT) begin : g_q2_direct
      assert_q2_direct_R6: assert property (@(posedge clk_i) disable iff (rst_i || set_i)
         1'b1 |=> q2_o == $past(byp_i));
   end else begin : g_q2_mux
      assert_q2_mux_R5: assert property (@(posedge clk_i) disable iff (rst_i || set_i)
         1'b1 |=> q2_o == $past(n_o));
   end
endmodule

// File: tb/lc_cell_bench.sv
`timescale 1ns/1ps
module lc_cell_bench;
   import lc_pkg::*;

   localparam int AW = 6;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic set_s, rst_s;
   logic [AW-1:0] and_a, and_f;
   logic [1:0] up_sel, m_sel, lo_sel, n_sel;
   logic up_d0, up_d1a, up_d1b, lo_d0, lo_d1a, lo_d1b, byp;

   logic a0, f0, m0, n0, q10, q20;
   logic a1, f1, m1, n1, q11, q21;

   lc_cell #(.AND_WIDTH(AW), .Q2_SRC(SRC_MUX)) u_lc_cell (
      .clk_i(clk), .set_i(set_s), .rst_i(rst_s), .and_a_i(and_a), .and_f_i(and_f),
      .up_sel_i(up_sel), .up_d0_i(up_d0), .up_d1a_i(up_d1a), .up_d1b_i(up_d1b),
      .m_sel_i(m_sel), .lo_sel_i(lo_sel), .lo_d0_i(lo_d0), .lo_d1a_i(lo_d1a),
      .lo_d1b_i(lo_d1b), .n_sel_i(n_sel), .byp_i(byp),
      .a_o(a0), .f_o(f0), .m_o(m0), .n_o(n0), .q1_o(q10), .q2_o(q20));

   lc_cell #(.AND_WIDTH(AW), .Q2_SRC(SRC_DIRECT)) u_lc_cell_direct (
      .clk_i(clk), .set_i(set_s), .rst_i(rst_s), .and_a_i(and_a), .and_f_i(and_f),
      .up_sel_i(up_sel), .up_d0_i(up_d0), .up_d1a_i(up_d1a), .up_d1b_i(up_d1b),
      .m_sel_i(m_sel), .lo_sel_i(lo_sel), .lo_d0_i(lo_d0), .lo_d1a_i(lo_d1a),
      .lo_d1b_i(lo_d1b), .n_sel_i(n_sel), .byp_i(byp),
      .a_o(a1), .f_o(f1), .m_o(m1), .n_o(n1), .q1_o(q11), .q2_o(q21));

   int checks = 0;
   int failures = 0;
   logic exp_q1, exp_q2m, exp_q2d;
   bit done = 1'b0;

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference of the combinational function
   function automatic logic ref_and(input logic [AW-1:0] v);
      for (int i = 0; i < AW; i++) if (v[i] == 1'b0) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic ref_tree(input logic [1:0] fs, input logic [1:0] os,
                                     input logic g, input logic d0,
                                     input logic d1a, input logic d1b);
      bit u = (fs == 2'b11);
      bit o = (os == 2'b11);
      if (o) return u ? d1b : d1a;
      return u ? d0 : g;
   endfunction

   function automatic logic ref_m();
      return ref_tree(up_sel, m_sel, ref_and(and_a), up_d0, up_d1a, up_d1b);
   endfunction

   function automatic logic ref_n();
      return ref_tree(lo_sel, n_sel, ref_and(and_f), lo_d0, lo_d1a, lo_d1b);
   endfunction

   task automatic check_comb(input string ctx);
      chk({"R1 a_o ", ctx}, a0, ref_and(and_a));
      chk({"R1 f_o ", ctx}, f0, ref_and(and_f));
      chk({"R2 m_o ", ctx}, m0, ref_m());
      chk({"R3 n_o ", ctx}, n0, ref_n());
      chk({"R1 a_o direct ", ctx}, a1, ref_and(and_a));
      chk({"R3 n_o direct ", ctx}, n1, ref_n());
   endtask

   task automatic check_regs(input string ctx);
      chk({"R4 q1 ", ctx}, q10, exp_q1);
      chk({"R4 q1 direct ", ctx}, q11, exp_q1);
      chk({"R5 q2 mux ", ctx}, q20, exp_q2m);
      chk({"R6 q2 direct ", ctx}, q21, exp_q2d);
   endtask

   task automatic drive_random();
      and_a  = AW'($urandom);
      and_f  = AW'($urandom);
      if ($urandom_range(3) == 0) and_a = '1;
      if ($urandom_range(3) == 0) and_f = '1;
      up_sel = 2'($urandom); m_sel = 2'($urandom);
      lo_sel = 2'($urandom); n_sel = 2'($urandom);
      {up_d0, up_d1a, up_d1b, lo_d0, lo_d1a, lo_d1b, byp} = 7'($urandom);
   endtask

   // Entered at negedge+2 with inputs just driven; leaves at the next negedge+2
   task automatic clock_step(input string ctx);
      #1;
      check_comb(ctx);
      exp_q1  = ref_m();
      exp_q2m = ref_n();
      exp_q2d = byp;
      @(posedge clk);
      @(negedge clk);
      #1;
      check_regs(ctx);
      #1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_s = 1'b1; set_s = 1'b0;
      and_a = '0; and_f = '0;
      up_sel = '0; m_sel = '0; lo_sel = '0; n_sel = '0;
      {up_d0, up_d1a, up_d1b, lo_d0, lo_d1a, lo_d1b, byp} = '0;
      exp_q1 = 1'b0; exp_q2m = 1'b0; exp_q2d = 1'b0;

      repeat (3) @(negedge clk);
      #1;
      check_regs("reset state R8");
      #1;
      rst_s = 1'b0;

      // Random patterns, compared on every clock
      for (int k = 0; k < 400; k++) begin
         drive_random();
         clock_step("random");
      end

      // R1 boundary: all ones, then a single zero at each position
      and_a = '1; and_f = '1;
      clock_step("and all ones");
      for (int b = 0; b < AW; b++) begin
         and_a = '1; and_a[b] = 1'b0;
         and_f = '1; and_f[b] = 1'b0;
         clock_step("and single zero");
      end

      // R5/R6: lower tree gives 1, bypass gives 0, then the reverse
      lo_sel = 2'b11; n_sel = 2'b11; lo_d1b = 1'b1; byp = 1'b0;
      clock_step("tree one bypass zero");
      lo_d1b = 1'b0; byp = 1'b1;
      clock_step("tree zero bypass one");

      // R7: asynchronous set, no clock edge needed
      drive_random();
      #1;
      set_s = 1'b1;
      #1;
      chk("R7 set async q1", q10, 1'b1);
      chk("R7 set async q2", q20, 1'b1);
      chk("R7 set async q2 direct", q21, 1'b1);
      check_comb("R9 during set");
      @(posedge clk);
      @(negedge clk);
      #1;
      chk("R7 set held q1", q10, 1'b1);
      chk("R7 set held q2 direct", q21, 1'b1);

      // R8: reset overrides set
      rst_s = 1'b1;
      #1;
      chk("R8 reset over set q1", q10, 1'b0);
      chk("R8 reset over set q2", q20, 1'b0);
      chk("R8 reset over set q1 direct", q11, 1'b0);
      check_comb("R9 during reset");
      @(posedge clk);
      @(negedge clk);
      #1;
      chk("R8 reset held q2 direct", q21, 1'b0);
      set_s = 1'b0;
      #1;
      rst_s = 1'b0;
      exp_q1 = 1'b0; exp_q2m = 1'b0; exp_q2d = 1'b0;
      #1;
      check_regs("after release R8");
      @(negedge clk);
      #2;

      for (int k = 0; k < 100; k++) begin
         drive_random();
         clock_step("random after reset");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule